// File: doc/BRIEF.md
# DDR burst-of-two synchronous SRAM

A synthesizable model of a synchronous SRAM with a double-data-rate data interface and a small internal array. It runs on a single clock at twice the interface rate. An internal phase register divides each interface cycle into a rise half and a fall half, and the block exports that phase on `ck_o`. Address, advance/load, read/write and the three chip enables are sampled only at the end of a rise half. Every access moves two data words. The word selected by the lowest internal address bit set to 0 travels in the rise half, and its partner with that bit set to 1 travels in the fall half. The external address is therefore one bit narrower than the word index.

Reads are pipelined. The array is read during the access cycle, and the two words appear on `q_o` in the rise and fall halves of the next interface cycle, with `q_oe_o` marking when the bus is driven. Writes take the rise-half word with the address and the fall-half word half a cycle later. Both words are committed at the end of that same cycle, so a read issued on the next cycle already returns them.

An echo clock pair follows the read data pipeline. It runs whenever the second and third chip enables were active in the sampling cycle, whatever the state of the first enable. It stops with the same latency as read data.

Top module: `sram_ddr2`

## Requirements
- R1: `ck_o` is high during a rise half and low during a fall half. It alternates on every `clk_i` cycle, and the first half after reset is a rise half.
- R2: A write is requested by `adv_ni`=0, `we_ni`=0 and the device selected (`en1_ni`=0, `en2_i`=1, `en3_ni`=0) in a rise half. `d_i` from that rise half is stored at word {addr,0}, and `d_i` from the following fall half is stored at word {addr,1}.
- R3: A read is requested the same way but with `we_ni`=1. In the next interface cycle `q_oe_o` is 1 in both halves, `q_o` carries word {addr,0} in the rise half and word {addr,1} in the fall half.
- R4: Reads on consecutive interface cycles give an unbroken stream of data words with `q_oe_o` held high.
- R5: A read on the interface cycle right after a write to the same address returns the newly written words.
- R6: With `en1_ni`=1, `en2_i`=0 or `en3_ni`=1 sampled, no operation starts: the array is unchanged and the bus is not driven in the next cycle.
- R7: With `adv_ni`=1 sampled, no operation starts: the array is unchanged and the bus is not driven in the next cycle.
- R8: Whenever `q_oe_o` is 0, `q_o` is all zeros.
- R9: `cq_o` is high in the rise half and `cq_n_o` is high in the fall half of interface cycle k+1 exactly when `en2_i`=1 and `en3_ni`=0 were sampled in cycle k, regardless of `en1_ni`, `adv_ni` and `we_ni`. Otherwise both are low. They are never high together.
- R10: During and right after reset, `q_oe_o`, `q_o`, `cq_o` and `cq_n_o` are low.
- R11: Values on `addr_i`, `adv_ni`, `we_ni` and the enables during a fall half have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the interface rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Pair address (word index without its lowest bit) |
| adv_ni | input | 1 | Advance/load, low loads a new operation |
| we_ni | input | 1 | Low for write, high for read |
| en1_ni | input | 1 | Chip enable 1, active low, does not gate echo |
| en2_i | input | 1 | Chip enable 2, active high, gates echo |
| en3_ni | input | 1 | Chip enable 3, active low, gates echo |
| d_i | input | DATA_W | Write data, one word per half |
| q_o | output | DATA_W | Read data, one word per half |
| q_oe_o | output | 1 | High while a read word is driven |
| ck_o | output | 1 | Interface phase, high in rise halves |
| cq_o | output | 1 | Echo clock, pulses in rise halves |
| cq_n_o | output | 1 | Complementary echo clock, pulses in fall halves |

## Verification
The assertions check on every cycle that the phase alternates, that a sampled read raises the output enable two clocks later for both halves, that an idle or deselected cycle leaves the bus undriven, that the bus is zero when not driven, and that echo on/off follows the second and third enables with data latency. Only the bench can show that the words are the right ones. That means checking the pairing of {addr,0} and {addr,1} to the halves, read-after-write coherence, writes blocked by a deselect or a high advance/load leaving old contents in place, and garbage on control inputs during fall halves being ignored. It does this with a reference array it keeps itself.

// File: rtl/sram_ddr2_pkg.sv
package sram_ddr2_pkg;
  localparam int BEATS = 2;

  function automatic logic chip_sel(input logic e1n, input logic e2, input logic e3n);
    return !e1n && e2 && !e3n;
  endfunction

  function automatic logic echo_sel(input logic e2, input logic e3n);
    return e2 && !e3n;
  endfunction
endpackage

// File: rtl/sram_ddr2_ctrl.sv
module sram_ddr2_ctrl #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic              en1_ni,
  input  logic              en2_i,
  input  logic              en3_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic              fall_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              echo_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wd0_o
);
  import sram_ddr2_pkg::*;

  logic load;
  assign load = !adv_ni && chip_sel(en1_ni, en2_i, en3_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_o <= 1'b0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      echo_o <= 1'b0;
      addr_o <= '0;
      wd0_o  <= '0;
    end else begin
      fall_o <= ~fall_o;
      // command and first write word only at the end of a rise half
      if (!fall_o) begin
        rd_o   <= load && we_ni;
        wr_o   <= load && !we_ni;
        echo_o <= echo_sel(en2_i, en3_ni);
        addr_o <= addr_i;
        wd0_o  <= d_i;
      end
    end
  end
endmodule

// File: rtl/sram_ddr2_array.sv
module sram_ddr2_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic                                        clk_i,
  input  logic                                        wr_i,
  input  logic [ADDR_W-1:0]                           addr_i,
  input  logic [sram_ddr2_pkg::BEATS-1:0][DATA_W-1:0] wd_i,
  output logic [sram_ddr2_pkg::BEATS-1:0][DATA_W-1:0] rd_o
);
  import sram_ddr2_pkg::*;
  localparam int ROWS = 1 << ADDR_W;

  // one bank per beat: the implicit low address bit selects the bank
  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    always_ff @(posedge clk_i) begin
      if (wr_i) mem[addr_i] <= wd_i[b];
    end
    assign rd_o[b] = mem[addr_i];
  end
endmodule

// File: rtl/sram_ddr2_rdpipe.sv
module sram_ddr2_rdpipe #(
  parameter int DATA_W = 18
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        fall_i,
  input  logic                                        rd_i,
  input  logic                                        echo_i,
  input  logic [sram_ddr2_pkg::BEATS-1:0][DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0]                           q_o,
  output logic                                        oe_o,
  output logic                                        cq_o,
  output logic                                        cq_n_o
);
  logic [DATA_W-1:0] hold_q;
  logic              cq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o     <= '0;
      hold_q  <= '0;
      oe_o    <= 1'b0;
      cq_en_q <= 1'b0;
    end else if (fall_i) begin
      // end of access cycle: launch first word, park the second
      oe_o    <= rd_i;
      q_o     <= rd_i ? rd_data_i[0] : '0;
      hold_q  <= rd_i ? rd_data_i[1] : '0;
      cq_en_q <= echo_i;
    end else begin
      q_o <= hold_q;
    end
  end

  assign cq_o   = cq_en_q & ~fall_i;
  assign cq_n_o = cq_en_q & fall_i;
endmodule

// File: rtl/sram_ddr2.sv
module sram_ddr2 #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic              en1_ni,
  input  logic              en2_i,
  input  logic              en3_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_oe_o,
  output logic              ck_o,
  output logic              cq_o,
  output logic              cq_n_o
);
  import sram_ddr2_pkg::*;

  logic                          fall, rd_s, wr_s, echo_s;
  logic [ADDR_W-1:0]             addr_s;
  logic [DATA_W-1:0]             wd0_s;
  logic [BEATS-1:0][DATA_W-1:0]  wd, rdat;

  sram_ddr2_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .adv_ni, .we_ni, .en1_ni, .en2_i, .en3_ni, .d_i,
    .fall_o(fall), .rd_o(rd_s), .wr_o(wr_s), .echo_o(echo_s),
    .addr_o(addr_s), .wd0_o(wd0_s)
  );

  assign wd = {d_i, wd0_s};

  // self-timed commit at the end of the fall half of the write cycle
  sram_ddr2_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .wr_i(wr_s & fall), .addr_i(addr_s), .wd_i(wd), .rd_o(rdat)
  );

  sram_ddr2_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk_i, .rst_ni, .fall_i(fall), .rd_i(rd_s), .echo_i(echo_s),
    .rd_data_i(rdat), .q_o, .oe_o(q_oe_o), .cq_o, .cq_n_o
  );

  assign ck_o = ~fall;
endmodule

// File: rtl/sram_ddr2_chk.sv
module sram_ddr2_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adv_ni,
  input logic              we_ni,
  input logic              en1_ni,
  input logic              en2_i,
  input logic              en3_ni,
  input logic [DATA_W-1:0] q_o,
  input logic              q_oe_o,
  input logic              ck_o,
  input logic              cq_o,
  input logic              cq_n_o
);
  logic rd_req, echo_req;
  assign rd_req   = ck_o && !adv_ni && !en1_ni && en2_i && !en3_ni && we_ni;
  assign echo_req = en2_i && !en3_ni;

  AST_PHASE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) ck_o |=> !ck_o); // R1
  AST_PHASE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) !ck_o |=> ck_o); // R1
  AST_READ_BOTH_HALVES: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_req |-> ##2 q_oe_o ##1 q_oe_o); // R3
  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) (ck_o && !(!en1_ni && en2_i && !en3_ni)) |-> ##2 !q_oe_o); // R6
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) (ck_o && adv_ni) |-> ##2 !q_oe_o ##1 !q_oe_o); // R7
  AST_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) !q_oe_o |-> (q_o == '0)); // R8
  AST_ECHO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni) (ck_o && echo_req) |-> ##2 cq_o ##1 cq_n_o); // R9
  AST_ECHO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) (ck_o && !echo_req) |-> ##2 !cq_o ##1 !cq_n_o); // R9
  AST_ECHO_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(cq_o && cq_n_o)); // R9
endmodule

bind sram_ddr2 sram_ddr2_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv_ni(adv_ni), .we_ni(we_ni),
  .en1_ni(en1_ni), .en2_i(en2_i), .en3_ni(en3_ni), .q_o(q_o),
  .q_oe_o(q_oe_o), .ck_o(ck_o), .cq_o(cq_o), .cq_n_o(cq_n_o)
);

// File: tb/sram_ddr2_test.sv
module sram_ddr2_test;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int WORDS = 2 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic adv_ni = 1'b1, we_ni = 1'b1, en1_ni = 1'b1, en2_i = 1'b0, en3_ni = 1'b1;
  logic [DW-1:0] d_i = '0;
  logic [DW-1:0] q_o;
  logic q_oe_o, ck_o, cq_o, cq_n_o;

  always #2 clk_i = ~clk_i;

  sram_ddr2 #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i, .rst_ni, .addr_i, .adv_ni, .we_ni, .en1_ni, .en2_i, .en3_ni,
    .d_i, .q_o, .q_oe_o, .ck_o, .cq_o, .cq_n_o
  );

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] model [WORDS];
  logic exp_oe = 0, exp_cq = 0;
  logic [DW-1:0] exp_q0 = '0, exp_q1 = '0;
  string oe_tag = "R10", q_tag = "R10", force_tag = "";
  logic prev_wr = 0, prev_rd = 0;
  logic [AW-1:0] prev_a = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return DW'($urandom());
  endfunction

  // one interface cycle; entered at the negedge that opens a rise half
  task automatic cyc(input logic [AW-1:0] a, input logic adv_n, input logic we_n,
                     input logic e1n, input logic e2, input logic e3n,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    logic on;
    addr_i = a; adv_ni = adv_n; we_ni = we_n;
    en1_ni = e1n; en2_i = e2; en3_ni = e3n; d_i = d0;
    chk("R1", "ck rise", ck_o, 1);
    chk(oe_tag, "oe rise", q_oe_o, exp_oe);
    chk(q_tag, "q rise", q_o, exp_oe ? exp_q0 : '0);
    chk("R9", "cq rise", cq_o, exp_cq);
    chk("R9", "cq_n rise", cq_n_o, 0);
    @(negedge clk_i);
    // R11: garbage on sampled-on-rise inputs during the fall half
    addr_i = AW'($urandom()); adv_ni = 1'($urandom()); we_ni = 1'($urandom());
    en1_ni = 1'($urandom()); en2_i = 1'($urandom()); en3_ni = 1'($urandom());
    d_i = d1;
    chk("R1", "ck fall", ck_o, 0);
    chk(oe_tag, "oe fall", q_oe_o, exp_oe);
    chk(q_tag, "q fall", q_o, exp_oe ? exp_q1 : '0);
    chk("R9", "cq fall", cq_o, 0);
    chk("R9", "cq_n fall", cq_n_o, exp_cq);
    on = !e1n && e2 && !e3n;
    exp_cq = e2 && !e3n;
    exp_oe = !adv_n && on && we_n;
    if (exp_oe) begin
      exp_q0 = model[{a, 1'b0}];
      exp_q1 = model[{a, 1'b1}];
      oe_tag = "R3";
      q_tag = (prev_wr && prev_a == a) ? "R5" : prev_rd ? "R4" : "R2";
    end else begin
      oe_tag = adv_n ? "R7" : !on ? "R6" : "R8";
      q_tag = oe_tag;
    end
    if (force_tag != "") begin
      q_tag = force_tag;
    end
    if (!adv_n && on && !we_n) begin
      model[{a, 1'b0}] = d0;
      model[{a, 1'b1}] = d1;
    end
    prev_wr = !adv_n && on && !we_n;
    prev_rd = exp_oe;
    prev_a = a;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    cyc(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, d0, d1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    cyc(a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, rnd_data(), rnd_data());
  endtask

  task automatic idle();
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R10", "oe in reset", q_oe_o, 0);
    chk("R10", "q in reset", q_o, 0);
    chk("R10", "cq in reset", cq_o, 0);
    chk("R10", "cq_n in reset", cq_n_o, 0);
    rst_ni = 1'b1;
    chk("R10", "ck first half", ck_o, 1);
    // fill every location (R2)
    for (int a = 0; a < (1 << AW); a++) wr(AW'(a), rnd_data(), rnd_data());
    // streaming reads (R3, R4)
    for (int a = 0; a < (1 << AW); a++) rd(AW'(a));
    idle();
    // read right after write (R5)
    wr(5, 18'h2AAAA, 18'h15555);
    rd(5);
    rd(5);
    // deselected writes leave contents (R6)
    force_tag = "R6";
    cyc(3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h11111, 18'h22222);
    cyc(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h11111, 18'h22222);
    cyc(3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 18'h11111, 18'h22222);
    rd(3);
    // echo with only en1 deasserted: no data, echo runs (R9)
    cyc(3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
    idle();
    // advance/load high blocks the write (R7)
    force_tag = "R7";
    cyc(7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h33333, 18'h00FFF);
    rd(7);
    idle();
    // fall-half garbage is ignored (R11)
    force_tag = "R11";
    wr(9, 18'h3C3C3, 18'h0F0F0);
    rd(9);
    force_tag = "";
    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic adv_n, we_n, e1n, e2, e3n;
      adv_n = ($urandom() % 8) == 0;
      we_n  = 1'($urandom());
      e1n   = ($urandom() % 10) == 0;
      e2    = ($urandom() % 10) != 0;
      e3n   = ($urandom() % 10) == 0;
      cyc(AW'($urandom()), adv_n, we_n, e1n, e2, e3n, rnd_data(), rnd_data());
    end
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule